// File: doc/BRIEF.md
# Message Interrupt Register Bank

This block holds eight 32-bit message registers that producers signal by writing a single index register. Each index write names one message register and one bit inside it. That bit is OR-ed into the register, and the register's interrupt request goes high. A consumer reads a message register to collect the bits that have built up in it. The read also empties the register and drops its request. A summary register gives one bit per message register, so software can find the non-empty ones without draining them.

Access is through a plain 32-bit register bus that uses byte offsets. The write side and the read side each have their own strobe and address, so a write and a read can happen in the same cycle. Read data is registered: it appears on the cycle after the read strobe and holds its value until the next read. There is one interrupt request output per message register. Decoding of the larger address map and prioritising between the requests are left to the surrounding logic.

Top module: `msg_irq_bank`

## Requirements
- R1: Reset clears all message registers, deasserts every interrupt request and sets read data to zero.
- R2: A write at offset 0x140 selects message register `wdata[31:29]` and bit `wdata[28:24]`. It ORs that bit into the register, keeps the bits already set, and the register's request is high on the cycle after the write.
- R3: A read at offset `n*0x10` (n from 0 to 7) returns message register n on `rdata` in the cycle after the read strobe.
- R4: Such a read leaves message register n at zero, so its request is low on the next cycle and a second read returns zero.
- R5: A read at offset 0x120 returns a word in which bit i is 1 exactly when message register i is non-zero, and bits 31:8 are zero. The read changes no register.
- R6: A write at any 16-byte-aligned offset other than 0x140 changes no register and no request.
- R7: An access whose offset has any of bits 3:0 set has no effect. Such a read returns 0xFFFFFFFF and clears nothing, and such a write sets nothing.
- R8: When a clearing read of register n and an index write to register n fall in the same cycle, the read returns the old contents. Afterwards the register holds only the newly written bit, and its request stays high.
- R9: An aligned read at an offset that maps to no register returns zero and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write byte offset |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 12 | Read byte offset |
| rdata | output | 32 | Registered read data, valid the cycle after `rd_en` |
| irq | output | 8 | Request per message register, high while that register is non-zero |

## Verification
Any bad internal state shows up at the ports within one cycle. A request line is a direct view of whether its register is empty, and the summary read exposes all eight of them in the next `rdata`. A bit set in the wrong register or at the wrong position shows as a wrong value on the following clearing read. A failed clear shows as a request that stays high and as a non-zero second read. The bench checks the same-cycle clear-and-set case and the misaligned accesses at the ports, because they are the only accesses in which a read strobe must not empty the register.

// File: rtl/msg_irq_bank.sv
module msg_irq_bank #(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] INDEX_OFS = 12'h140,
  parameter logic [ADDR_W-1:0] SUMMARY_OFS = 12'h120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wdata,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rdata,
  output logic [NUM_REGS-1:0] irq
);
  localparam int SEL_W = $clog2(NUM_REGS);
  localparam int POS_W = 5;
  localparam int SLOT_W = ADDR_W - 4;

  logic [31:0] bank [NUM_REGS];
  logic [31:0] rd_next;

  wire             idx_wr   = wr_en && (wr_addr == INDEX_OFS);
  wire [SEL_W-1:0] set_sel  = wdata[31 -: SEL_W];
  wire [POS_W-1:0] set_pos  = wdata[28:24];
  wire             rd_align = (rd_addr[3:0] == 4'h0);
  wire [SLOT_W-1:0] rd_slot = rd_addr[ADDR_W-1:4];
  wire             rd_msg   = rd_align && (rd_slot < SLOT_W'(NUM_REGS));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    logic [31:0] val;
    wire         clr  = rd_en && rd_msg && (rd_slot == SLOT_W'(g));
    wire         hit  = idx_wr && (set_sel == SEL_W'(g));
    wire [31:0]  sbit = hit ? (32'h1 << set_pos) : 32'h0;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          val <= '0;
      else if (clr || hit) val <= (clr ? 32'h0 : val) | sbit;

    assign bank[g] = val;
    assign irq[g]  = |val;
  end

  always_comb begin
    rd_next = '0;
    if (!rd_align)                   rd_next = '1;
    else if (rd_msg)                 rd_next = bank[rd_slot[SEL_W-1:0]];
    else if (rd_addr == SUMMARY_OFS) rd_next = {{(32-NUM_REGS){1'b0}}, irq};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_next;
endmodule

module msg_irq_bank_chk #(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] INDEX_OFS = 12'h140,
  parameter logic [ADDR_W-1:0] SUMMARY_OFS = 12'h120
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wdata,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rdata,
  input logic [NUM_REGS-1:0] irq
);
  localparam int SEL_W = $clog2(NUM_REGS);

  wire             c_idx = wr_en && (wr_addr == INDEX_OFS);
  wire [SEL_W-1:0] c_sel = wdata[31 -: SEL_W];

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (irq == '0));

  // R2
  index_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_idx |=> irq[$past(c_sel)]);

  // R5
  summary_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == SUMMARY_OFS) |=> (rdata == {{(32-NUM_REGS){1'b0}}, $past(irq)}));

  // R6
  other_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != INDEX_OFS && !rd_en) |=> $stable(irq));

  // R7
  misaligned_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr[3:0] != 4'h0) |=> (rdata == 32'hFFFF_FFFF));

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_k
    wire rd_k = rd_en && (rd_addr == ADDR_W'(k * 16));
    // R4
    clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_k && !(c_idx && c_sel == SEL_W'(k))) |=> !irq[k]);
    // R8
    collide_keeps_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_k && c_idx && c_sel == SEL_W'(k)) |=> irq[k]);
  end
endmodule

bind msg_irq_bank msg_irq_bank_chk #(
  .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .INDEX_OFS(INDEX_OFS), .SUMMARY_OFS(SUMMARY_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata),
  .rd_en(rd_en), .rd_addr(rd_addr), .rdata(rdata), .irq(irq)
);

// File: tb/msg_irq_bank_bench.sv
module msg_irq_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
  } vec_t;

  // write: data is wdata; read: data is expected rdata
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 12'h140, 32'h4500_0000},
    '{1'b1, 12'h140, 32'h4000_0000},
    '{1'b1, 12'h140, 32'hFF00_0000},
    '{1'b0, 12'h120, 32'h0000_0084},
    '{1'b0, 12'h020, 32'h0000_0021},
    '{1'b0, 12'h020, 32'h0000_0000},
    '{1'b0, 12'h120, 32'h0000_0080},
    '{1'b1, 12'h100, 32'hFF00_0000},
    '{1'b1, 12'h141, 32'h0000_0000},
    '{1'b0, 12'h120, 32'h0000_0080},
    '{1'b0, 12'h078, 32'hFFFF_FFFF},
    '{1'b0, 12'h070, 32'h8000_0000},
    '{1'b0, 12'h070, 32'h0000_0000},
    '{1'b0, 12'h0A0, 32'h0000_0000},
    '{1'b1, 12'h140, 32'h1F00_0000},
    '{1'b0, 12'h000, 32'h8000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rdata;
  logic [7:0]  irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  msg_irq_bank u_msg_irq_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rdata(rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state straight out of reset
    chk("R1 irq", {24'h0, irq}, 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].wr) do_write(VECS[i].addr, VECS[i].data);
      else begin
        do_read(VECS[i].addr);
        if (VECS[i].addr[3:0] != 4'h0)  chk("R7 misaligned read", rdata, VECS[i].data);
        else if (VECS[i].addr == 12'h120) chk("R5 summary", rdata, VECS[i].data);
        else if (VECS[i].addr < 12'h080)  chk("R3 message read", rdata, VECS[i].data);
        else                              chk("R9 unmapped read", rdata, VECS[i].data);
      end
    end

    // R2: request follows the index write
    do_write(12'h140, 32'h2000_0000);
    chk("R2 irq after write", {24'h0, irq}, 32'h0000_0002);
    // R6: write elsewhere leaves requests alone
    do_write(12'h130, 32'h6000_0000);
    chk("R6 irq unchanged", {24'h0, irq}, 32'h0000_0002);
    // R7: misaligned read clears nothing
    do_read(12'h014);
    chk("R7 no clear irq", {24'h0, irq}, 32'h0000_0002);
    // R4: clearing read drops the request
    do_read(12'h010);
    chk("R3 read reg1", rdata, 32'h0000_0001);
    chk("R4 irq low", {24'h0, irq}, 32'h0);

    // R8: clear and set of register 3 in the same cycle
    do_write(12'h140, 32'h6100_0000);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 12'h030;
    wr_en = 1'b1; wr_addr = 12'h140; wdata = 32'h6400_0000;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk("R8 old value read", rdata, 32'h0000_0002);
    chk("R8 irq held", {24'h0, irq}, 32'h0000_0008);
    do_read(12'h030);
    chk("R8 new bit only", rdata, 32'h0000_0010);

    // R1: reset in mid-run empties the bank
    do_write(12'h140, 32'hA300_0000);
    chk("R2 irq reg5", {24'h0, irq}, 32'h0000_0020);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 irq after reset", {24'h0, irq}, 32'h0);
    chk("R1 rdata after reset", rdata, 32'h0);
    rst_n = 1'b1;
    do_read(12'h050);
    chk("R1 reg5 empty", rdata, 32'h0);

    finish_run();
  end
endmodule